// File: doc/BRIEF.md
# Serial Interrupt Slave Frame Controller

This block is the peripheral end of a single shared open-drain interrupt line. The line is clocked by the host bus clock. Five local interrupt sources each pass through a gate built from a host enable bit and an output-buffer-full flag. The gated level of each source is placed into its own frame of the serial cycle. The host may start a cycle at any time. At the end of each cycle, the length of the host's stop pulse tells the slave whether later cycles run continuously or only on request ("quiet"). In quiet mode, the slave starts a cycle itself when its interrupt picture changes.

The state machine has these states:

| State | Meaning |
|---|---|
| IDLE | Line released, waiting. |
| REQ | The slave pulls the line low for one clock to ask for a cycle. |
| START | The host holds the start pulse. |
| SAMPLE | First of three frame phases. |
| RECOVER | Second of three frame phases. |
| TURN | Third of three frame phases. |
| STOP | Waiting for the stop pulse. |
| STOP_LOW | Measuring the stop pulse. |

The transitions are:

- IDLE→START when the line is seen low.
- IDLE→REQ when the block is quiet, a request is pending and the line is high.
- REQ→START always.
- START→SAMPLE when the line is seen high.
- SAMPLE→RECOVER→TURN, one clock each.
- TURN→SAMPLE with the frame number incremented, for all frames but the last.
- TURN→STOP after the last frame.
- STOP→STOP_LOW when the line is seen low.
- STOP_LOW→IDLE when the line is seen high.

A synchronous soft reset forces IDLE from any state.

Top module: `sirq_slave`

## Requirements
- R1: After hardware reset the quiet flag is 0 and the slave does not drive the line.
- R2: Frames are counted from 0, starting with the first clock after the start pulse ends. Each frame is three clocks long. Source 0 (SMI) owns frame 2, source 1 frame 6, source 2 frame 9, source 3 frame 10 and source 4 frame 11. In the first clock of an owned frame, the slave releases the line (it reads 1) if the gated source is active, and drives it to 0 if the source is inactive. The slave never drives frames it does not own.
- R3: In the second clock of an owned frame the slave drives the line to 1. In the third clock of every frame the line is released.
- R4: With the direct bit at 0, a source is active only when both its enable bit and its buffer-full flag are 1.
- R5: With the direct bit at 1, a source is active whenever its enable bit is 1, whatever its buffer-full flag.
- R6: After frame 16, the line is counted low for N clocks. N=2 sets the quiet flag to 1. N=3 clears it to 0. Any other N leaves it unchanged.
- R7: A soft reset pulse clears the quiet flag and any pending request. The slave then drives nothing.
- R8: With the quiet flag at 0, the slave never drives the line outside the frames of a host-started cycle.
- R9: With the quiet flag at 1, a gated source going 0→1 makes the slave pull the idle line low for exactly one clock and then release it.
- R10: With the policy bit at 0 in quiet mode, a source going 1→0 raises a request only if no gated source is still active.
- R11: With the policy bit at 1 in quiet mode, any gated source going 1→0 raises a request.
- R12: A pending request is withdrawn once a start pulse is seen, so a finished cycle leaves the idle line undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Soft reset, synchronous, active high |
| sirq_in | input | 1 | Sensed level of the serial interrupt line |
| sirq_oe | output | 1 | 1 when the slave drives the line |
| sirq_out | output | 1 | Value driven when sirq_oe is 1 |
| host_en | input | 5 | Host enable per source: bit 0 SMI, bits 1..4 IRQ6, IRQ9, IRQ10, IRQ11 |
| obf | input | 5 | Output-buffer-full flag per source, same bit order |
| direct_mode | input | 1 | 1: enable bit alone gates a source |
| req_any_clear | input | 1 | Quiet-mode policy: 1 requests on any clear, 0 only when all are clear |
| quiet_mode | output | 1 | Mode taken from the last stop pulse: 1 quiet, 0 continuous |

## Verification
The assertions assume the host never drives the line while the slave drives it to the opposite value. They also assume that enable and flag inputs change only on inactive clock phases. The stimulus plays the host role from negative clock edges only. It changes the source inputs only while the line is idle, and it takes over the start pulse during the slave's one-clock request. Stop pulses of 2, 3 and 4 clocks are driven so that every branch of the mode decision is reached.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int NUM_SRC    = 5;
    localparam int NUM_FRAMES = 17;
    localparam int STOP_QUIET = 2;
    localparam int STOP_CONT  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_START,
        ST_SAMPLE,
        ST_RECOVER,
        ST_TURN,
        ST_STOP,
        ST_STOP_LOW
    } sirq_state_e;
endpackage

// File: rtl/sirq_src_gate.sv
module sirq_src_gate #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_rst,
    input  logic [N-1:0] host_en,
    input  logic [N-1:0] obf,
    input  logic         direct_mode,
    input  logic         req_any_clear,
    input  logic         start_seen,
    output logic [N-1:0] gated,
    output logic         pending
);
    logic [N-1:0] prev;
    logic         rise, fall_any, fall_all, req_evt;

    always_comb begin
        gated    = host_en & (obf | {N{direct_mode}});
        rise     = |(gated & ~prev);
        fall_any = |(prev & ~gated);
        fall_all = (|prev) && !(|gated);
        req_evt  = rise || (req_any_clear ? fall_any : fall_all);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev    <= '0;
            pending <= 1'b0;
        end else if (sw_rst) begin
            prev    <= gated;
            pending <= 1'b0;
        end else begin
            prev <= gated;
            if (req_evt)
                pending <= 1'b1;
            else if (start_seen)
                pending <= 1'b0;
        end
    end

    // R9: a newly active source leaves a request behind
    p_rise_pends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !sw_rst) |=> pending);
    // R7: soft reset withdraws any request
    p_swrst_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> !pending);
endmodule

// File: rtl/sirq_frame_map.sv
module sirq_frame_map #(
    parameter int N  = 5,
    parameter int FW = 5,
    parameter logic [N-1:0][7:0] SRC_FRAME = {8'd11, 8'd10, 8'd9, 8'd6, 8'd2}
) (
    input  logic [FW-1:0] frame,
    input  logic [N-1:0]  gated,
    output logic          owned,
    output logic          active
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign hit[i] = (int'(frame) == int'(SRC_FRAME[i]));
    end

    assign owned  = |hit;
    assign active = |(hit & gated);
endmodule

// File: rtl/sirq_cycle_fsm.sv
module sirq_cycle_fsm
    import sirq_pkg::*;
#(
    parameter int NFRM = 17,
    parameter int FW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_rst,
    input  logic          line_in,
    input  logic          pending,
    input  logic          owned,
    input  logic          active,
    output logic [FW-1:0] frame,
    output logic          quiet,
    output logic          start_seen,
    output logic          drive_en,
    output logic          drive_val
);
    localparam logic [FW-1:0] LAST = FW'(NFRM - 1);
    localparam int CW = 3;

    sirq_state_e state, nstate;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (sw_rst) state <= ST_IDLE;
        else             state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:     if (!line_in) nstate = ST_START;
                         else if (quiet && pending) nstate = ST_REQ;
            ST_REQ:      nstate = ST_START;
            ST_START:    if (line_in) nstate = ST_SAMPLE;
            ST_SAMPLE:   nstate = ST_RECOVER;
            ST_RECOVER:  nstate = ST_TURN;
            ST_TURN:     nstate = (frame == LAST) ? ST_STOP : ST_SAMPLE;
            ST_STOP:     if (!line_in) nstate = ST_STOP_LOW;
            ST_STOP_LOW: if (line_in) nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame   <= '0;
            low_cnt <= '0;
            quiet   <= 1'b0;
        end else if (sw_rst) begin
            frame   <= '0;
            low_cnt <= '0;
            quiet   <= 1'b0;
        end else begin
            if (state == ST_START)
                frame <= '0;
            else if (state == ST_TURN && frame != LAST)
                frame <= frame + 1'b1;
            if (state == ST_STOP && !line_in)
                low_cnt <= CW'(1);
            else if (state == ST_STOP_LOW && !line_in && low_cnt != '1)
                low_cnt <= low_cnt + 1'b1;
            if (state == ST_STOP_LOW && line_in) begin
                if (low_cnt == CW'(STOP_QUIET))     quiet <= 1'b1;
                else if (low_cnt == CW'(STOP_CONT)) quiet <= 1'b0;
            end
        end
    end

    always_comb begin
        drive_en   = 1'b0;
        drive_val  = 1'b1;
        start_seen = 1'b0;
        unique case (state)
            ST_REQ:     begin drive_en = 1'b1; drive_val = 1'b0; end
            ST_START:   start_seen = 1'b1;
            ST_SAMPLE:  if (owned && !active) begin
                            drive_en = 1'b1; drive_val = 1'b0;
                        end
            ST_RECOVER: if (owned) begin
                            drive_en = 1'b1; drive_val = 1'b1;
                        end
            default:    ;
        endcase
    end

    // R9: a request pulse lasts one clock
    p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ) |=> (state != ST_REQ));
    // R3: turnaround clock is always released
    p_turn_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |-> !drive_en);
    // R6: the mode flag moves only at the end of a stop pulse or by soft reset
    p_mode_at_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(quiet) && !$past(sw_rst)) |-> ($past(state) == ST_STOP_LOW));
    // R8: continuous mode leaves the idle line alone
    p_cont_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !quiet) |-> !drive_en);
endmodule

// File: rtl/sirq_slave.sv
module sirq_slave
    import sirq_pkg::*;
#(
    parameter int N    = NUM_SRC,
    parameter int NFRM = NUM_FRAMES,
    parameter logic [N-1:0][7:0] SRC_FRAME = {8'd11, 8'd10, 8'd9, 8'd6, 8'd2}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_rst,
    input  logic         sirq_in,
    output logic         sirq_oe,
    output logic         sirq_out,
    input  logic [N-1:0] host_en,
    input  logic [N-1:0] obf,
    input  logic         direct_mode,
    input  logic         req_any_clear,
    output logic         quiet_mode
);
    localparam int FW = $clog2(NFRM);

    logic [N-1:0]  gated;
    logic          pending, start_seen, owned, active;
    logic [FW-1:0] frame;

    sirq_src_gate #(.N(N)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_rst        (sw_rst),
        .host_en       (host_en),
        .obf           (obf),
        .direct_mode   (direct_mode),
        .req_any_clear (req_any_clear),
        .start_seen    (start_seen),
        .gated         (gated),
        .pending       (pending)
    );

    sirq_frame_map #(.N(N), .FW(FW), .SRC_FRAME(SRC_FRAME)) u_map (
        .frame  (frame),
        .gated  (gated),
        .owned  (owned),
        .active (active)
    );

    sirq_cycle_fsm #(.NFRM(NFRM), .FW(FW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst     (sw_rst),
        .line_in    (sirq_in),
        .pending    (pending),
        .owned      (owned),
        .active     (active),
        .frame      (frame),
        .quiet      (quiet_mode),
        .start_seen (start_seen),
        .drive_en   (sirq_oe),
        .drive_val  (sirq_out)
    );
endmodule

// File: tb/sirq_slave_test.sv
module sirq_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0, sw_rst = 1'b0;
    logic host_low = 1'b0;
    logic [4:0] host_en = '0, obf = '0;
    logic direct_mode = 1'b0, req_any_clear = 1'b0;
    logic sirq_oe, sirq_out, quiet_mode, line;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    localparam logic [16:0] OWN = 17'h00E44;

    always #2.5 clk = ~clk;

    assign line = sirq_oe ? sirq_out : !host_low;

    sirq_slave uut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .sirq_in(line),
        .sirq_oe(sirq_oe), .sirq_out(sirq_out), .host_en(host_en), .obf(obf),
        .direct_mode(direct_mode), .req_any_clear(req_any_clear),
        .quiet_mode(quiet_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_frames(input logic [4:0] g);
        logic [16:0] e = '1;
        e[2] = g[0]; e[6] = g[1]; e[9] = g[2]; e[10] = g[3]; e[11] = g[4];
        return e;
    endfunction

    // Host-side cycle; 'already' means the host took over during a slave request
    task automatic host_cycle(input bit already, input int stop_len, input logic [4:0] g, input string tag);
        logic [16:0] smp = '0;
        int bad_rec = 0, bad_turn = 0;
        if (already) begin
            host_low = 1'b1;
            @(negedge clk);
            chk(!sirq_oe, "R9 request released after one clock", sirq_oe, 0);
            repeat (2) @(negedge clk);
        end else begin
            @(negedge clk); host_low = 1'b1;
            repeat (4) @(negedge clk);
        end
        host_low = 1'b0;
        for (int f = 0; f < 17; f++) begin
            @(negedge clk); smp[f] = line;
            @(negedge clk);
            if (OWN[f] ? !(sirq_oe && sirq_out) : sirq_oe) bad_rec++;
            @(negedge clk);
            if (sirq_oe) bad_turn++;
        end
        chk(smp == exp_frames(g), {"R2 ", tag}, smp, exp_frames(g));
        chk(bad_rec == 0 && bad_turn == 0, "R3 recovery/turnaround", bad_rec + bad_turn, 0);
        @(negedge clk); host_low = 1'b1;
        repeat (stop_len) @(negedge clk);
        host_low = 1'b0;
        @(negedge clk);
    endtask

    task automatic watch_quiet(input int n, input string tag);
        int drv = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (sirq_oe) drv++;
        end
        chk(drv == 0, tag, drv, 0);
    endtask

    task automatic wait_req(input string tag);
        bit found = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (sirq_oe && !sirq_out) begin found = 1'b1; break; end
        end
        chk(found, tag, found, 1);
    endtask

    task automatic t_reset();
        chk(quiet_mode == 1'b0, "R1 quiet flag at reset", quiet_mode, 0);
        chk(sirq_oe == 1'b0, "R1 line released at reset", sirq_oe, 0);
    endtask

    task automatic t_gate_obf();
        direct_mode = 1'b0; host_en = 5'b11111; obf = 5'b10101;
        host_cycle(1'b0, 3, 5'b10101, "R4 enable and flag");
        host_en = 5'b01110; obf = 5'b11011;
        host_cycle(1'b0, 3, 5'b01010, "R4 partial");
        chk(quiet_mode == 1'b0, "R6 three-clock stop keeps continuous", quiet_mode, 0);
    endtask

    task automatic t_direct();
        direct_mode = 1'b1; host_en = 5'b10011; obf = 5'b00000;
        host_cycle(1'b0, 4, 5'b10011, "R5 enable alone");
        chk(quiet_mode == 1'b0, "R6 four-clock stop leaves flag", quiet_mode, 0);
    endtask

    task automatic t_continuous_idle();
        host_en = 5'b00000;
        @(negedge clk); host_en = 5'b11111;
        watch_quiet(10, "R8 no drive when continuous");
    endtask

    task automatic t_quiet_entry();
        host_cycle(1'b0, 2, 5'b11111, "R2 all active");
        chk(quiet_mode == 1'b1, "R6 two-clock stop sets quiet", quiet_mode, 1);
        watch_quiet(8, "R12 no request after cycle");
        host_cycle(1'b0, 4, 5'b11111, "R2 quiet cycle");
        chk(quiet_mode == 1'b1, "R6 four-clock stop keeps quiet", quiet_mode, 1);
    endtask

    task automatic t_rise_req();
        host_en = 5'b11111; req_any_clear = 1'b0;
        @(negedge clk); host_en = 5'b00000;
        wait_req("R10 all cleared requests");
        host_cycle(1'b1, 2, 5'b00000, "R2 none active");
        @(negedge clk); host_en = 5'b01000;
        wait_req("R9 rise requests");
        host_cycle(1'b1, 2, 5'b01000, "R2 single source");
        watch_quiet(8, "R12 request withdrawn");
    endtask

    task automatic t_sel0();
        req_any_clear = 1'b0;
        @(negedge clk); host_en = 5'b01001;
        wait_req("R9 second rise");
        host_cycle(1'b1, 2, 5'b01001, "R2 two sources");
        @(negedge clk); host_en = 5'b00001;
        watch_quiet(8, "R10 partial clear ignored");
        @(negedge clk); host_en = 5'b00000;
        wait_req("R10 last clear requests");
        host_cycle(1'b1, 2, 5'b00000, "R2 cleared");
    endtask

    task automatic t_sel1();
        req_any_clear = 1'b1;
        @(negedge clk); host_en = 5'b00110;
        wait_req("R9 rise under policy 1");
        host_cycle(1'b1, 2, 5'b00110, "R2 policy 1");
        @(negedge clk); host_en = 5'b00100;
        wait_req("R11 single clear requests");
        host_cycle(1'b1, 2, 5'b00100, "R2 after single clear");
    endtask

    task automatic t_swrst();
        chk(quiet_mode == 1'b1, "R6 quiet before soft reset", quiet_mode, 1);
        @(negedge clk); sw_rst = 1'b1; host_en = 5'b00000;
        @(negedge clk); sw_rst = 1'b0;
        chk(quiet_mode == 1'b0, "R7 soft reset clears flag", quiet_mode, 0);
        watch_quiet(6, "R7 no drive after soft reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_gate_obf();
        t_direct();
        t_continuous_idle();
        t_quiet_entry();
        t_rise_req();
        t_sel0();
        t_sel1();
        t_swrst();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule